// File: doc/BRIEF.md
# I2C Wiper Controller for a 256-Tap Digital Potentiometer

This block is the digital side of a serially programmed resistor ladder. It sits on a two-wire I2C bus as a slave. It holds one 8-bit wiper code and drives the switch controls of the ladder from that code. A fast system clock samples SCL and SDA. The block finds bus START and STOP conditions itself and answers its own 7-bit address. One bit of that address comes from a strap input, so two such controllers can share a bus.

In a write transaction, the byte after the address is a command byte. That byte can restore the wiper to mid-scale and can switch the ladder into a power-down state. Every byte after the command byte is taken as a new wiper code, until the bus stops. In a read transaction, the block returns the stored code. It keeps returning the code for as long as the master acknowledges each byte.

In power-down, terminal A is opened and the wiper is tied to terminal B. The stored code is preserved, and new codes can still be written. The open-drain SDA pad is represented by a single pull-low enable.

Top module: `wiper_i2c_slave`

## Requirements
- R1: After reset the stored code is 0x80, `tap_code_o` is 0x80, both power-down flags are low and `sda_drive_low_o` is low.
- R2: The slave address is the 7 bits 0,1,0,1,1,0 followed by `addr_sel_i`, sent MSB first and followed by the R/W bit (0 write, 1 read). On a match the slave pulls SDA low through the ninth SCL pulse. Any other address gets no acknowledge, and every later byte up to the next START is neither acknowledged nor applied.
- R3: The slave only starts pulling SDA low after a falling SCL edge. It only releases SDA after a falling SCL edge or at a START or STOP.
- R4: In a write, the first byte after the address is a command byte and is acknowledged. Its bit 6 set to 1 loads 0x80 into the stored code. Bits 7 and 4..0 have no effect.
- R5: Bit 5 of the command byte sets the power-down state when it is 1 and clears it when it is 0. While power-down is set, `term_a_open_o` and `wiper_to_b_o` are high, `tap_code_o` is 0x00, and the stored code is kept unchanged.
- R6: Each byte after the command byte in a write is acknowledged and replaces the stored code. The last one before STOP remains in the register.
- R7: Codes written while powered down are stored. They appear on `tap_code_o` once a later command byte clears bit 5.
- R8: In a read, the slave shifts out the stored code MSB first, starting right after its address acknowledge. It sends the code again after every master ACK. After a master NACK it releases SDA and stays silent.
- R9: A repeated START at any point in a transaction restarts address decoding.
- R10: A STOP ends the transaction and leaves SDA released.
- R11: While not powered down, `tap_code_o` equals the stored code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| addr_sel_i | input | 1 | Strap that sets the last address bit |
| sda_drive_low_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| tap_code_o | output | 8 | Effective tap selected on the ladder |
| term_a_open_o | output | 1 | Power-down: terminal A disconnected |
| wiper_to_b_o | output | 1 | Power-down: wiper shorted to terminal B |

## Verification
The assertions check several rules on every cycle:
- The slave only ever starts pulling the bus low just after a sampled SCL fall.
- It only lets go after a fall, a START or a STOP.
- The stored code only changes right after a sampled SCL rise.
- The power-down state only changes after a decoded command byte.
- A mid-scale command always leaves 0x80 behind.

Address matching, command-bit decoding, multi-byte writes, data kept through power-down, read repetition and repeated START can only be shown by the bench. It runs whole bus transactions and compares the acknowledges, the read data and the outputs with a model it keeps itself.

// File: rtl/dp_pkg.sv
package dp_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_INSTR,
    PH_WDATA,
    PH_RDATA
  } phase_e;
endpackage

// File: rtl/dp_bus_sampler.sv
module dp_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p, scl_s;

  // Synchronizer chains reset to the idle (high) bus level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_p  <= scl_ff[SYNC_STAGES-1];
      sda_p  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_ff[SYNC_STAGES-1];
  assign sda_s     = sda_ff[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/dp_wiper_reg.sv
module dp_wiper_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_code,
  input  logic              cmd_en,
  input  logic              cmd_mid,
  input  logic              cmd_off,
  output logic [DATA_W-1:0] code_q,
  output logic              off_q,
  output logic [DATA_W-1:0] tap_code
);
  localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

  logic [DATA_W-1:0] code_n;
  logic              off_n;

  always_comb begin
    code_n = code_q;
    off_n  = off_q;
    if (cmd_en) begin
      off_n = cmd_off;
      if (cmd_mid) code_n = MID_CODE;
    end else if (load_en) begin
      code_n = load_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= MID_CODE;
      off_q  <= 1'b0;
    end else if (cmd_en || load_en) begin
      code_q <= code_n;
      off_q  <= off_n;
    end
  end

  assign tap_code = off_q ? '0 : code_q;
endmodule

// File: rtl/dp_link_fsm.sv
module dp_link_fsm
  import dp_pkg::*;
#(
  parameter int              DATA_W     = 8,
  parameter int              ADDR_W     = 7,
  parameter logic [ADDR_W-2:0] ADDR_FIXED = 6'b010110,
  parameter int              MID_BIT    = 6,
  parameter int              OFF_BIT    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic              addr_sel,
  input  logic [DATA_W-1:0] rd_code,
  output logic              sda_low,
  output logic              load_en,
  output logic [DATA_W-1:0] load_code,
  output logic              cmd_en,
  output logic              cmd_mid,
  output logic              cmd_off
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  phase_e            phase_q, phase_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W-1:0] sh_q, sh_n, nb;
  logic [DATA_W-2:0] tx_q, tx_n;
  logic              low_n, ackp_q, ackp_n, rw_q, rw_n;

  assign nb        = {sh_q[DATA_W-2:0], sda_s};
  assign load_code = nb;
  assign cmd_mid   = nb[MID_BIT];
  assign cmd_off   = nb[OFF_BIT];

  always_comb begin
    phase_n = phase_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    tx_n    = tx_q;
    low_n   = sda_low;
    ackp_n  = ackp_q;
    rw_n    = rw_q;
    load_en = 1'b0;
    cmd_en  = 1'b0;
    if (start_det) begin
      phase_n = PH_ADDR;
      cnt_n   = '0;
      low_n   = 1'b0;
      ackp_n  = 1'b0;
    end else if (stop_det) begin
      phase_n = PH_IDLE;
      cnt_n   = '0;
      low_n   = 1'b0;
      ackp_n  = 1'b0;
    end else if (phase_q != PH_IDLE) begin
      if (scl_rise) begin
        if (cnt_q != ACK_SLOT) begin
          sh_n  = nb;
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            unique case (phase_q)
              PH_ADDR: begin
                if (nb[DATA_W-1 -: ADDR_W] == {ADDR_FIXED, addr_sel}) begin
                  ackp_n = 1'b1;
                  rw_n   = nb[0];
                end else begin
                  phase_n = PH_IDLE;
                end
              end
              PH_INSTR: begin
                ackp_n = 1'b1;
                cmd_en = 1'b1;
              end
              PH_WDATA: begin
                ackp_n  = 1'b1;
                load_en = 1'b1;
              end
              default: ;
            endcase
          end
        end else begin
          cnt_n = '0;
          unique case (phase_q)
            PH_ADDR:  phase_n = rw_q ? PH_RDATA : PH_INSTR;
            PH_INSTR: phase_n = PH_WDATA;
            PH_RDATA: if (sda_s) phase_n = PH_IDLE;
            default: ;
          endcase
        end
      end else if (scl_fall) begin
        if (cnt_q == ACK_SLOT) begin
          low_n = ackp_q;
        end else if (cnt_q == '0) begin
          ackp_n = 1'b0;
          if (phase_q == PH_RDATA) begin
            tx_n  = rd_code[DATA_W-2:0];
            low_n = ~rd_code[DATA_W-1];
          end else begin
            low_n = 1'b0;
          end
        end else if (phase_q == PH_RDATA) begin
          tx_n  = {tx_q[DATA_W-3:0], 1'b0};
          low_n = ~tx_q[DATA_W-2];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      sda_low <= 1'b0;
      ackp_q  <= 1'b0;
      rw_q    <= 1'b0;
    end else begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      tx_q    <= tx_n;
      sda_low <= low_n;
      ackp_q  <= ackp_n;
      rw_q    <= rw_n;
    end
  end
endmodule

// File: rtl/wiper_i2c_slave.sv
module wiper_i2c_slave #(
  parameter int                DATA_W      = 8,
  parameter int                ADDR_W      = 7,
  parameter logic [ADDR_W-2:0] ADDR_FIXED  = 6'b010110,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  output logic              sda_drive_low_o,
  output logic [DATA_W-1:0] tap_code_o,
  output logic              term_a_open_o,
  output logic              wiper_to_b_o
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              load_en, cmd_en, cmd_mid, cmd_off, off_q;
  logic [DATA_W-1:0] load_code, code_q;

  dp_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  dp_link_fsm #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ADDR_FIXED(ADDR_FIXED)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .addr_sel(addr_sel_i), .rd_code(code_q), .sda_low(sda_drive_low_o),
    .load_en(load_en), .load_code(load_code), .cmd_en(cmd_en),
    .cmd_mid(cmd_mid), .cmd_off(cmd_off)
  );

  dp_wiper_reg #(.DATA_W(DATA_W)) u_wiper (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_code(load_code),
    .cmd_en(cmd_en), .cmd_mid(cmd_mid), .cmd_off(cmd_off),
    .code_q(code_q), .off_q(off_q), .tap_code(tap_code_o)
  );

  assign term_a_open_o = off_q;
  assign wiper_to_b_o  = off_q;
endmodule

// File: rtl/dp_checker.sv
module dp_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_drive_low_o,
  input logic              scl_rise,
  input logic              scl_fall,
  input logic              start_det,
  input logic              stop_det,
  input logic              cmd_en,
  input logic              cmd_mid,
  input logic [DATA_W-1:0] code_q,
  input logic              off_q
);
  localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

  // R3: pull-low begins only after a sampled SCL fall
  a_r3_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low_o) |-> $past(scl_fall));

  // R3 / R10: release only after a fall, a START or a STOP
  a_r3_release_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_drive_low_o) |-> $past(scl_fall || start_det || stop_det));

  // R6: stored code only moves on the clock edge after an SCL rise
  a_r6_code_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(code_q) |-> $past(scl_rise));

  // R5: power-down state changes only after a decoded command byte
  a_r5_off_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(off_q) |-> $past(cmd_en));

  // R4: a mid-scale command leaves 0x80 in the register
  a_r4_mid_load: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_en && cmd_mid) |-> (code_q == MID_CODE));
endmodule

bind wiper_i2c_slave dp_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_drive_low_o(sda_drive_low_o),
  .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
  .stop_det(stop_det), .cmd_en(cmd_en), .cmd_mid(cmd_mid),
  .code_q(code_q), .off_q(off_q)
);

// File: tb/tb_wiper_i2c_slave.sv
module tb_wiper_i2c_slave;
  localparam int H = 16;

  logic clk, rst_n, scl, m_sda, addr_sel;
  logic sda_drive_low_o, term_a_open_o, wiper_to_b_o;
  logic [7:0] tap_code_o;
  wire  sda_line = m_sda & ~sda_drive_low_o;

  int total = 0, bad = 0, r3_viol = 0;
  bit done = 0;
  logic [7:0] exp_code;
  logic       exp_off;

  wiper_i2c_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_sel_i(addr_sel), .sda_drive_low_o(sda_drive_low_o),
    .tap_code_o(tap_code_o), .term_a_open_o(term_a_open_o),
    .wiper_to_b_o(wiper_to_b_o)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  // R3: the slave must never change its pull while SCL is high
  always @(sda_drive_low_o) if (rst_n === 1'b1 && scl === 1'b1) r3_viol++;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1; hold(H); scl = 1; hold(H); m_sda = 0; hold(H); scl = 0; hold(H);
  endtask

  task automatic bus_stop();
    m_sda = 0; hold(H); scl = 1; hold(H); m_sda = 1; hold(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hold(H); scl = 1; hold(H); scl = 0; hold(2);
    end
    m_sda = 1; hold(H); scl = 1; hold(H / 2); ack = ~sda_line;
    hold(H / 2); scl = 0; hold(2);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      hold(H); scl = 1; hold(H / 2); d[i] = sda_line; hold(H / 2); scl = 0; hold(2);
    end
    m_sda = mack ? 1'b0 : 1'b1; hold(H); scl = 1; hold(H); scl = 0; hold(2);
    m_sda = 1;
  endtask

  task automatic check_outputs(input string tag);
    check({tag, " tap"}, tap_code_o, exp_off ? 8'h00 : exp_code);
    check({tag, " a_open"}, term_a_open_o, exp_off);
    check({tag, " w_to_b"}, wiper_to_b_o, exp_off);
  endtask

  // write: address 0x58, command byte, optional data byte
  task automatic do_write(input logic [7:0] instr, input bit with_data,
                          input logic [7:0] code, input string tag);
    logic ack;
    bus_start();
    send_byte(8'h58, ack); check({tag, " addr ack"}, ack, 1);
    send_byte(instr, ack); check({tag, " cmd ack"}, ack, 1);
    if (instr[6]) exp_code = 8'h80;
    exp_off = instr[5];
    if (with_data) begin
      send_byte(code, ack); check({tag, " data ack"}, ack, 1);
      exp_code = code;
    end
    bus_stop();
  endtask

  task automatic do_read(input string tag);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte(8'h59, ack); check({tag, " R8 read addr ack"}, ack, 1);
    recv_byte(1'b0, d);
    check({tag, " R8 read data"}, d, exp_code);
    bus_stop();
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    rst_n = 0; scl = 1; m_sda = 1; addr_sel = 0;
    exp_code = 8'h80; exp_off = 0;
    hold(10);
    rst_n = 1;
    hold(10);
    // R1 reset state
    check("R1 tap", tap_code_o, 8'h80);
    check("R1 a_open", term_a_open_o, 0);
    check("R1 w_to_b", wiper_to_b_o, 0);
    check("R1 sda", sda_drive_low_o, 0);

    // R2 address sweep with strap high: only 0x2D answers
    addr_sel = 1;
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({a[6:0], 1'b0}, ack);
      check("R2 address sweep ack", ack, (a == 7'h2D) ? 1 : 0);
      bus_stop();
    end
    check_outputs("R2 after sweep");
    addr_sel = 0;

    // R2 mismatched address: later bytes ignored until next START
    bus_start();
    send_byte(8'h5A, ack); check("R2 wrong addr nack", ack, 0);
    send_byte(8'h00, ack); check("R2 ignored cmd nack", ack, 0);
    send_byte(8'h12, ack); check("R2 ignored data nack", ack, 0);
    bus_stop();
    check_outputs("R2 ignored write");

    // R6 / R11 / R8 code sweep
    for (int i = 0; i < 16; i++) begin
      do_write(8'h00, 1, 8'(i * 17), "R6 sweep");
      check_outputs("R11 sweep");
      do_read("R8 sweep");
    end

    // R6 several data bytes in one write
    bus_start();
    send_byte(8'h58, ack); check("R6 multi addr ack", ack, 1);
    send_byte(8'h00, ack); check("R6 multi cmd ack", ack, 1);
    send_byte(8'h21, ack); check("R6 multi d0 ack", ack, 1);
    send_byte(8'h7E, ack); check("R6 multi d1 ack", ack, 1);
    send_byte(8'hB4, ack); check("R6 multi d2 ack", ack, 1);
    bus_stop();
    exp_code = 8'hB4; exp_off = 0;
    check_outputs("R6 multi");

    // R4 don't-care bits only: no change
    do_write(8'h9F, 0, 8'h00, "R4 dont care");
    check_outputs("R4 dont care");
    // R4 mid-scale with don't-care bits set
    do_write(8'hDF, 0, 8'h00, "R4 midscale");
    check_outputs("R4 midscale");
    check("R4 midscale value", tap_code_o, 8'h80);

    // R5 power-down keeps code
    do_write(8'h00, 1, 8'h5A, "R5 preload");
    do_write(8'h20, 0, 8'h00, "R5 off");
    check_outputs("R5 off");
    do_read("R5 stored kept");
    // R7 write while powered down
    do_write(8'h20, 1, 8'hC3, "R7 write off");
    check_outputs("R7 write off");
    do_read("R7 stored");
    do_write(8'h00, 0, 8'h00, "R7 wake");
    check_outputs("R7 wake");
    check("R7 wake code", tap_code_o, 8'hC3);

    // R9 repeated START: write then read in one bus ownership
    bus_start();
    send_byte(8'h58, ack); check("R9 addr ack", ack, 1);
    send_byte(8'h00, ack); check("R9 cmd ack", ack, 1);
    send_byte(8'h11, ack); check("R9 data ack", ack, 1);
    exp_code = 8'h11;
    bus_start();
    send_byte(8'h59, ack); check("R9 read addr ack", ack, 1);
    recv_byte(1'b0, d); check("R9 read data", d, 8'h11);
    bus_stop();
    // R9 mismatch then repeated START to a matching address
    bus_start();
    send_byte(8'h70, ack); check("R9 mismatch nack", ack, 0);
    bus_start();
    send_byte(8'h59, ack); check("R9 rematch ack", ack, 1);
    recv_byte(1'b0, d); check("R9 rematch data", d, 8'h11);
    bus_stop();

    // R8 repeated read with ACK, ACK, NACK; R10 release after STOP
    bus_start();
    send_byte(8'h59, ack); check("R8 multi addr ack", ack, 1);
    recv_byte(1'b1, d); check("R8 multi d0", d, 8'h11);
    recv_byte(1'b1, d); check("R8 multi d1", d, 8'h11);
    recv_byte(1'b0, d); check("R8 multi d2", d, 8'h11);
    check("R8 released after nack", sda_drive_low_o, 0);
    bus_stop();
    check("R10 released after stop", sda_drive_low_o, 0);
    check_outputs("R10 end");

    check("R3 no pull change while SCL high", r3_viol, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule